// File: doc/BRIEF.md
# Memory Request Arbiter with Urgent Tier and Switchable Lower Tier

This block chooses which of four memory requesters owns the memory port. An urgent display source sits alone in a top tier and wins every contest it enters. Below it, the processor, the graphics pipeline and the background (non-urgent) display source form a lower tier. A single mode input sets how that tier is ordered. When `rotate_dis` is low, the three lower sources take turns through a rotating pointer. When `rotate_dis` is high, the processor ranks first.

The arbiter has one registered, one-hot grant vector. A grant stays with its owner until that owner pulses its `done` bit. A new winner can be chosen only at that boundary or while no grant is held, so an active grant is never preempted. The data paths belong to the surrounding logic.

Source positions in `req`, `done` and `gnt`:
- bit 0 is the urgent display.
- bit 1 is the processor.
- bit 2 is graphics.
- bit 3 is the background display.

Top module: `mem_req_arbiter`

## Requirements
- R1: After reset `gnt` is 4'b0000, and the rotation pointer selects the processor (bit 1).
- R2: At most one bit of `gnt` is set in any cycle.
- R3: While a grant is held and its owner's `done` bit is low, `gnt` does not change. This holds even if the owner drops its request, and `done` bits of other sources have no effect.
- R4: The port is free when `gnt` is zero or when the owner raises its `done` bit. A free port is granted on the next clock edge to one requesting source, or `gnt` becomes 4'b0000 if no bit of `req` is set.
- R5: When the port is free and `req[0]` is set, the next `gnt` is 4'b0001 in either mode.
- R6: With `rotate_dis` = 1 and `req[0]` clear, the lower tier is ranked strictly as processor (bit 1), then graphics (bit 2), then background display (bit 3).
- R7: With `rotate_dis` = 0 and `req[0]` clear, the search over bits 1, 2, 3 starts at the pointer and proceeds cyclically in the order 1, 2, 3, 1. The first requesting source found wins.
- R8: Every lower-tier grant, in either mode, moves the pointer to the source after the one granted, wrapping from bit 3 to bit 1. Urgent grants leave the pointer unchanged.
- R9: The mode input is read only when the port is free. Changing it while a grant is held does not affect that grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rotate_dis | input | 1 | 0 = lower tier rotates, 1 = processor-first fixed order |
| req | input | 4 | Request per source (bit 0 urgent, 1 processor, 2 graphics, 3 background display) |
| done | input | 4 | Owner's release pulse, same bit order |
| gnt | output | 4 | One-hot registered grant, same bit order |

## Verification
Two events can fall in one cycle: a release by the current owner and the award of the next grant, together with the pointer update that award causes. The bench provokes this in two ways. First, it raises the owner's `done` bit while every source is still requesting. Second, it lets an urgent request arrive during a rotation. It then judges the winner one edge later against the ranking that the pointer and the mode predict. Mode changes in the middle of a grant are checked so that the held grant stays fixed and the next award follows the new order.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;
    localparam int LOW_N  = 3;
    localparam int SRC_N  = LOW_N + 1;
    localparam int PTR_W  = $clog2(LOW_N);

    typedef logic [SRC_N-1:0] src_vec_t;
    typedef logic [PTR_W-1:0] ptr_t;

    typedef struct packed {
        src_vec_t gnt;
        ptr_t     ptr;
    } arb_state_t;
endpackage

// File: rtl/mem_arb_prio_enc.sv
module mem_arb_prio_enc #(
    parameter int W  = 3,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = |vec;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/mem_arb_lower_sel.sv
module mem_arb_lower_sel
    import mem_arb_pkg::*;
(
    input  logic [LOW_N-1:0] lreq,
    input  ptr_t             ptr,
    input  logic             rr_en,
    output logic             hit,
    output ptr_t             idx
);
    logic [LOW_N-1:0] rot;
    logic             rot_hit, fix_hit;
    ptr_t             rot_idx, fix_idx;

    always_comb begin
        for (int i = 0; i < LOW_N; i++) begin
            int k;
            k = int'(ptr) + i;
            if (k >= LOW_N) k = k - LOW_N;
            rot[i] = lreq[k];
        end
    end

    mem_arb_prio_enc #(.W(LOW_N)) u_rot (.vec(rot),  .hit(rot_hit), .idx(rot_idx));
    mem_arb_prio_enc #(.W(LOW_N)) u_fix (.vec(lreq), .hit(fix_hit), .idx(fix_idx));

    always_comb begin
        int k;
        k = int'(ptr) + int'(rot_idx);
        if (k >= LOW_N) k = k - LOW_N;
        if (rr_en) begin
            hit = rot_hit;
            idx = ptr_t'(k);
        end else begin
            hit = fix_hit;
            idx = fix_idx;
        end
    end

    // R4: a chosen lower source must be requesting
    always_comb begin
        if (hit) begin
            lower_pick_req_chk: assert (lreq[idx]);
        end
    end
endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter
    import mem_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rotate_dis,
    input  logic [SRC_N-1:0] req,
    input  logic [SRC_N-1:0] done,
    output logic [SRC_N-1:0] gnt
);
    arb_state_t st_d, st_q;
    logic       free_d;
    logic       low_hit_d;
    ptr_t       low_idx_d;

    mem_arb_lower_sel u_low (
        .lreq  (req[SRC_N-1:1]),
        .ptr   (st_q.ptr),
        .rr_en (~rotate_dis),
        .hit   (low_hit_d),
        .idx   (low_idx_d)
    );

    always_comb begin
        st_d   = st_q;
        free_d = (st_q.gnt == '0) || ((done & st_q.gnt) != '0);
        if (free_d) begin
            st_d.gnt = '0;
            if (req[0]) begin
                st_d.gnt[0] = 1'b1;
            end else if (low_hit_d) begin
                for (int i = 0; i < LOW_N; i++) begin
                    if (low_idx_d == ptr_t'(i)) st_d.gnt[i+1] = 1'b1;
                end
                st_d.ptr = (low_idx_d == ptr_t'(LOW_N - 1)) ? '0 : low_idx_d + ptr_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt = st_q.gnt;

    // R2
    onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R3
    hold_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && (done & gnt) == '0) |=> $stable(gnt));

    // R4
    idle_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt == '0 || (done & gnt) != '0) && req == '0) |=> gnt == '0);

    // R5
    urgent_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt == '0 || (done & gnt) != '0) && req[0]) |=> gnt == SRC_N'(1));

    // R6
    fixed_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt == '0 || (done & gnt) != '0) && rotate_dis && !req[0] && req[1])
        |=> gnt == SRC_N'(2));
endmodule

// File: tb/sim_mem_req_arbiter.sv
module sim_mem_req_arbiter;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rotate_dis = 1'b0;
    logic [3:0] req = '0;
    logic [3:0] done = '0;
    logic [3:0] gnt;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    mem_req_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .rotate_dis(rotate_dis),
        .req(req), .done(done), .gnt(gnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [3:0] exp);
        n_chk++;
        if (gnt !== exp) begin
            n_fail++;
            $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp);
        end
    endtask

    task automatic step(input logic [3:0] r, input logic [3:0] d);
        req  = r;
        done = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 reset", 4'b0000);
        step(4'b0000, 4'b0000);
        check("R4 idle", 4'b0000);
    endtask

    task automatic t_rotate();
        rotate_dis = 1'b0;
        step(4'b1110, 4'b0000); check("R1 R7 first rr pick cpu", 4'b0010);
        step(4'b1110, 4'b0000); check("R3 hold", 4'b0010);
        step(4'b1100, 4'b0000); check("R3 hold after req drop", 4'b0010);
        step(4'b1110, 4'b0010); check("R7 rr next gfx", 4'b0100);
        step(4'b1110, 4'b0100); check("R7 rr next bg", 4'b1000);
        step(4'b1110, 4'b1000); check("R8 rr wrap cpu", 4'b0010);
    endtask

    task automatic t_urgent();
        step(4'b1111, 4'b0000); check("R3 no preempt by urgent", 4'b0010);
        step(4'b1111, 4'b0010); check("R5 urgent wins rr", 4'b0001);
        step(4'b1111, 4'b0001); check("R5 urgent again", 4'b0001);
        step(4'b1110, 4'b0001); check("R8 ptr untouched by urgent", 4'b0100);
    endtask

    task automatic t_fixed();
        rotate_dis = 1'b1;
        step(4'b1110, 4'b0100); check("R6 cpu first", 4'b0010);
        step(4'b1110, 4'b0010); check("R6 cpu repeats", 4'b0010);
        step(4'b1100, 4'b0010); check("R6 gfx over bg", 4'b0100);
        step(4'b1000, 4'b0100); check("R6 bg alone", 4'b1000);
        step(4'b1101, 4'b1000); check("R5 urgent wins fixed", 4'b0001);
        step(4'b1100, 4'b0001); check("R6 gfx after urgent", 4'b0100);
        step(4'b0000, 4'b0100); check("R4 release to idle", 4'b0000);
    endtask

    task automatic t_stray();
        step(4'b1000, 4'b0000); check("R4 grant bg", 4'b1000);
        step(4'b0000, 4'b0111); check("R3 foreign done ignored", 4'b1000);
        step(4'b0000, 4'b1000); check("R4 release no req", 4'b0000);
    endtask

    task automatic t_mode();
        step(4'b0100, 4'b0000); check("R6 gfx granted", 4'b0100);
        rotate_dis = 1'b0;
        step(4'b1110, 4'b0000); check("R9 mode change holds grant", 4'b0100);
        step(4'b1110, 4'b0100); check("R8 R9 rr from ptr bg", 4'b1000);
        step(4'b0000, 4'b1000); check("R4 final idle", 4'b0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rotate();
        t_urgent();
        t_fixed();
        t_stray();
        t_mode();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule